// File: doc/BRIEF.md
# Two-Way Cache Controller with Most-Recently-Used Way Prediction

This controller manages a small two-way set-associative cache placed between a processor port and a main-memory port. The cache holds writes until a line is evicted, and a write miss loads the line into the cache. Every set carries one pointer bit that names the way hit last. Each access starts by driving that way's word onto the read bus, as a direct-mapped cache would. Tag compares then confirm the guess. If the other way holds the line, the controller switches ways and answers one cycle later.

On a miss the line that is replaced is always in the way the pointer does not name. If that line is dirty, it is first written back to memory as a whole line. The new line is then fetched, any write data is merged into it as it is installed, and the pointer moves to the newly filled way. The processor raises a request and holds the address, direction and write data until it sees ready. Main memory takes whole-line read or write requests and answers each with a one-cycle acknowledge.

Top module: `cmru_ctrl`

## Requirements
- R1: Reset clears every valid bit, pointer bit and dirty bit. After reset, cpu_ready and mem_req are low while no request is pending, and the first access to any line misses and fetches that line.
- R2: A read or write whose line is in the way named by the set's pointer raises cpu_ready in the same cycle as the request. cpu_rdata then carries that way's word.
- R3: A hit in the way not named by the pointer raises cpu_ready exactly one cycle after the request, with that way's word on cpu_rdata. That way becomes the pointed way, so an immediate repeat of the access answers in the same cycle.
- R4: On a miss, the replaced way is the one the set's pointer does not name, and the filled way becomes the pointed way. cpu_ready rises only after the line transfer has finished and is never high while mem_req is high.
- R5: When the replaced line is dirty, all four of its words are written to memory at the line's own address, and only then is the new line read. The read request follows the write acknowledge in the next cycle.
- R6: When the replaced line is clean or invalid, the miss makes exactly one line read and no memory write.
- R7: A write hit updates only the addressed word, marks the line dirty and makes no memory request.
- R8: A write miss fetches the line, merges the write word into it as it is installed, and leaves the line dirty. The other three words keep their memory values.
- R9: Every read returns the value last written to that word address, or the memory's value if the word was never written.
- R10: mem_req stays high, with mem_addr and mem_we unchanged, until mem_ack. mem_addr is the line address {tag, set}. In a word address, bits [1:0] select the word, bits [5:2] select the set and the bits above form the tag. In a line, word i occupies bits [32*i+31 : 32*i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while cpu_ready is high on a read |
| cpu_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | ADDR_W-2 | Line address {tag, set} |
| mem_wline | output | 4*DATA_W | Line data written back |
| mem_rline | input | 4*DATA_W | Fetched line, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the current line transfer |

## Verification
The cycle that installs a fetched line does several jobs at once. It merges the processor's write word into the incoming line, sets the dirty bit and moves the pointer, and it is often the cycle right after a dirty victim's write-back was acknowledged. The bench provokes this by confining much of its random traffic to three tags per set, so that write misses keep hitting sets whose victim line is dirty. It judges the result in two ways: the merged word and its neighbours must read back correctly, and the merged line must reappear intact in memory at the correct address when it is later evicted. A hit in the unpredicted way changes the pointer and commits a write in the same edge; alternating between two lines of one set checks this through the exact ready latency.

// File: rtl/cmru_pkg.sv
package cmru_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_LOOK  = 2'd0,
        ST_ALT   = 2'd1,
        ST_EVICT = 2'd2,
        ST_FETCH = 2'd3
    } cmru_state_e;
endpackage

// File: rtl/cmru_tag_store.sv
module cmru_tag_store
    import cmru_pkg::*;
#(
    parameter int SET_BITS = 4,
    parameter int TAG_W    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SET_BITS-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]     rd_tag,
    output logic [WAYS-1:0]                rd_valid,
    output logic [WAYS-1:0]                rd_dirty,
    output logic                           rd_mru,
    input  logic [SET_BITS-1:0]            wr_set,
    input  logic                           wr_way,
    input  logic                           touch_en,
    input  logic                           dirty_en,
    input  logic                           fill_en,
    input  logic                           fill_dirty,
    input  logic [TAG_W-1:0]               fill_tag
);
    localparam int SETS = 1 << SET_BITS;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0]            valid;
        logic [SETS-1:0][WAYS-1:0]            dirty;
        logic [SETS-1:0]                      mru;
    } tag_state_t;

    tag_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (fill_en) begin
            st_d.tag[wr_set][wr_way]   = fill_tag;
            st_d.valid[wr_set][wr_way] = 1'b1;
            st_d.dirty[wr_set][wr_way] = fill_dirty;
        end
        if (dirty_en) begin
            st_d.dirty[wr_set][wr_way] = 1'b1;
        end
        if (touch_en) begin
            st_d.mru[wr_set] = wr_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_tag   = st_q.tag[rd_set];
    assign rd_valid = st_q.valid[rd_set];
    assign rd_dirty = st_q.dirty[rd_set];
    assign rd_mru   = st_q.mru[rd_set];
endmodule

// File: rtl/cmru_data_store.sv
module cmru_data_store
    import cmru_pkg::*;
#(
    parameter int SET_BITS = 4,
    parameter int OFF_BITS = 2,
    parameter int DATA_W   = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SET_BITS-1:0]              rd_set,
    output logic [WAYS-1:0][(DATA_W<<OFF_BITS)-1:0] rd_line,
    input  logic [SET_BITS-1:0]              wr_set,
    input  logic                             wr_way,
    input  logic                             word_en,
    input  logic [OFF_BITS-1:0]              word_off,
    input  logic [DATA_W-1:0]                word_data,
    input  logic                             line_en,
    input  logic [(DATA_W<<OFF_BITS)-1:0]    line_data
);
    localparam int SETS   = 1 << SET_BITS;
    localparam int LINE_W = DATA_W << OFF_BITS;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][LINE_W-1:0] line;
    } data_state_t;

    data_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (line_en) begin
            st_d.line[wr_set][wr_way] = line_data;
        end
        if (word_en) begin
            st_d.line[wr_set][wr_way][word_off*DATA_W +: DATA_W] = word_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_line = st_q.line[rd_set];
endmodule

// File: rtl/cmru_hit_detect.sv
module cmru_hit_detect
    import cmru_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           req_tag,
    input  logic                       mru_way,
    output logic [WAYS-1:0]            way_hit,
    output logic                       mru_hit,
    output logic                       alt_hit
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    assign mru_hit = way_hit[mru_way];
    assign alt_hit = way_hit[~mru_way] && !way_hit[mru_way];
endmodule

// File: rtl/cmru_ctrl.sv
module cmru_ctrl
    import cmru_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int SET_BITS = 4,
    parameter int OFF_BITS = 2,
    parameter int DATA_W   = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cpu_req,
    input  logic                           cpu_we,
    input  logic [ADDR_W-1:0]              cpu_addr,
    input  logic [DATA_W-1:0]              cpu_wdata,
    output logic [DATA_W-1:0]              cpu_rdata,
    output logic                           cpu_ready,
    output logic                           mem_req,
    output logic                           mem_we,
    output logic [ADDR_W-OFF_BITS-1:0]     mem_addr,
    output logic [(DATA_W<<OFF_BITS)-1:0]  mem_wline,
    input  logic [(DATA_W<<OFF_BITS)-1:0]  mem_rline,
    input  logic                           mem_ack
);
    localparam int TAG_W   = ADDR_W - SET_BITS - OFF_BITS;
    localparam int LINE_W  = DATA_W << OFF_BITS;
    localparam int LINE_AW = ADDR_W - OFF_BITS;

    typedef struct packed {
        cmru_state_e state;
        logic        vic;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [SET_BITS-1:0]           req_set;
    logic [OFF_BITS-1:0]           req_off;
    logic [TAG_W-1:0]              req_tag;

    logic [WAYS-1:0][TAG_W-1:0]    ts_tag;
    logic [WAYS-1:0]               ts_valid;
    logic [WAYS-1:0]               ts_dirty;
    logic                          ts_mru;
    logic [WAYS-1:0][LINE_W-1:0]   ds_line;
    logic [WAYS-1:0]               way_hit;
    logic                          mru_hit;
    logic                          alt_hit;

    logic                          tgt_way;
    logic                          touch_en;
    logic                          dirty_en;
    logic                          fill_en;
    logic                          fill_dirty;
    logic                          word_en;
    logic                          line_en;
    logic [LINE_W-1:0]             merged;

    assign req_off = cpu_addr[OFF_BITS-1:0];
    assign req_set = cpu_addr[OFF_BITS +: SET_BITS];
    assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];

    cmru_tag_store #(
        .SET_BITS (SET_BITS),
        .TAG_W    (TAG_W)
    ) tags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_set     (req_set),
        .rd_tag     (ts_tag),
        .rd_valid   (ts_valid),
        .rd_dirty   (ts_dirty),
        .rd_mru     (ts_mru),
        .wr_set     (req_set),
        .wr_way     (tgt_way),
        .touch_en   (touch_en),
        .dirty_en   (dirty_en),
        .fill_en    (fill_en),
        .fill_dirty (fill_dirty),
        .fill_tag   (req_tag)
    );

    cmru_data_store #(
        .SET_BITS (SET_BITS),
        .OFF_BITS (OFF_BITS),
        .DATA_W   (DATA_W)
    ) data_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (req_set),
        .rd_line   (ds_line),
        .wr_set    (req_set),
        .wr_way    (tgt_way),
        .word_en   (word_en),
        .word_off  (req_off),
        .word_data (cpu_wdata),
        .line_en   (line_en),
        .line_data (merged)
    );

    cmru_hit_detect #(
        .TAG_W (TAG_W)
    ) hit_i (
        .way_tag   (ts_tag),
        .way_valid (ts_valid),
        .req_tag   (req_tag),
        .mru_way   (ts_mru),
        .way_hit   (way_hit),
        .mru_hit   (mru_hit),
        .alt_hit   (alt_hit)
    );

    always_comb begin
        ctl_d      = ctl_q;
        cpu_ready  = 1'b0;
        cpu_rdata  = ds_line[ts_mru][req_off*DATA_W +: DATA_W];
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {req_tag, req_set};
        mem_wline  = ds_line[ctl_q.vic];
        tgt_way    = ts_mru;
        touch_en   = 1'b0;
        dirty_en   = 1'b0;
        fill_en    = 1'b0;
        fill_dirty = 1'b0;
        word_en    = 1'b0;
        line_en    = 1'b0;
        merged     = mem_rline;
        if (cpu_we) begin
            merged[req_off*DATA_W +: DATA_W] = cpu_wdata;
        end

        unique case (ctl_q.state)
            ST_LOOK: begin
                if (cpu_req) begin
                    if (mru_hit) begin
                        cpu_ready = 1'b1;
                        word_en   = cpu_we;
                        dirty_en  = cpu_we;
                    end else if (alt_hit) begin
                        ctl_d.state = ST_ALT;
                    end else begin
                        ctl_d.vic = ~ts_mru;
                        if (ts_valid[~ts_mru] && ts_dirty[~ts_mru]) begin
                            ctl_d.state = ST_EVICT;
                        end else begin
                            ctl_d.state = ST_FETCH;
                        end
                    end
                end
            end
            ST_ALT: begin
                tgt_way     = ~ts_mru;
                cpu_rdata   = ds_line[~ts_mru][req_off*DATA_W +: DATA_W];
                cpu_ready   = 1'b1;
                touch_en    = 1'b1;
                word_en     = cpu_we;
                dirty_en    = cpu_we;
                ctl_d.state = ST_LOOK;
            end
            ST_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {ts_tag[ctl_q.vic], req_set};
                if (mem_ack) begin
                    ctl_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                tgt_way = ctl_q.vic;
                if (mem_ack) begin
                    line_en     = 1'b1;
                    fill_en     = 1'b1;
                    fill_dirty  = cpu_we;
                    touch_en    = 1'b1;
                    ctl_d.state = ST_LOOK;
                end
            end
            default: ctl_d.state = ST_LOOK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_LOOK, vic: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/cmru_ctrl_chk.sv
module cmru_ctrl_chk #(
    parameter int LINE_AW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_req,
    input logic               cpu_ready,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_ack,
    input logic [LINE_AW-1:0] mem_addr
);
    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5
    wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R4
    ready_not_in_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    // R2
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);
endmodule

bind cmru_ctrl cmru_ctrl_chk #(.LINE_AW(ADDR_W - OFF_BITS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/cmru_ctrl_tb.sv
module cmru_ctrl_tb_top;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int LW = 4 * DW;
    localparam int MEM_LAT = 2;
    localparam int NWORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_ready;
    logic          mem_req;
    logic          mem_we;
    logic [AW-3:0] mem_addr;
    logic [LW-1:0] mem_wline;
    logic [LW-1:0] mem_rline = '0;
    logic          mem_ack = 1'b0;

    always #5 clk = ~clk;

    cmru_ctrl #(.ADDR_W(AW), .SET_BITS(4), .OFF_BITS(2), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wline(mem_wline), .mem_rline(mem_rline),
        .mem_ack(mem_ack)
    );

    int total = 0;
    int fails = 0;

    // backing memory, golden values, memory traffic log
    logic [DW-1:0] mem  [NWORDS];
    logic [DW-1:0] gold [NWORDS];
    int            rd_cnt = 0;
    int            wr_cnt = 0;
    logic [AW-3:0] last_waddr = '0;
    logic [1:0]    ops = 2'b00;
    int            lat_cnt = 0;

    function automatic logic [DW-1:0] init_val(input int a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat_cnt == MEM_LAT) begin
                lat_cnt <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    for (int i = 0; i < 4; i++) mem[int'(mem_addr)*4+i] <= mem_wline[i*DW +: DW];
                    wr_cnt     <= wr_cnt + 1;
                    last_waddr <= mem_addr;
                    ops        <= {ops[0], 1'b1};
                end else begin
                    for (int i = 0; i < 4; i++) mem_rline[i*DW +: DW] <= mem[int'(mem_addr)*4+i];
                    rd_cnt <= rd_cnt + 1;
                    ops    <= {ops[0], 1'b0};
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // cache state model built from the requirements
    logic [3:0] mtag [16][2];
    bit         mval [16][2];
    bit         mdir [16][2];
    bit         mmru [16];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int lat, output logic [DW-1:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        lat = 0; rd = '0;
        forever begin
            #2;
            if (cpu_ready) begin
                rd = cpu_rdata;
                break;
            end
            if (lat > 500) break;
            @(negedge clk);
            lat++;
        end
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic run(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output int lat, output logic [DW-1:0] rd);
        int s = int'(a[5:2]);
        logic [3:0] t = a[9:6];
        int hw = -1;
        int cls;
        bit v = 1'b0;
        logic [AW-3:0] vline = '0;
        int r0, w0;
        for (int w = 0; w < 2; w++) if (mval[s][w] && mtag[s][w] == t) hw = w;
        if (hw >= 0) cls = (hw == int'(mmru[s])) ? 0 : 1;
        else begin
            v = ~mmru[s];
            cls = (mval[s][v] && mdir[s][v]) ? 3 : 2;
            vline = {mtag[s][v], a[5:2]};
        end
        r0 = rd_cnt; w0 = wr_cnt;
        access(we, a, d, lat, rd);
        if (cls == 0)      chk(lat == 0, "R2", "MRU-way hit latency", lat, 0);
        else if (cls == 1) chk(lat == 1, "R3", "other-way hit latency", lat, 1);
        else               chk(lat >= 2 && lat <= 500, "R4", "miss latency", lat, 2);
        if (cls < 2) chk(rd_cnt == r0 && wr_cnt == w0, we ? "R7" : "R2",
                         "memory traffic on hit", (rd_cnt - r0) + (wr_cnt - w0), 0);
        else         chk(rd_cnt - r0 == 1, "R4", "line fetches on miss", rd_cnt - r0, 1);
        if (cls == 2) chk(wr_cnt == w0, "R6", "write-backs for clean victim", wr_cnt - w0, 0);
        if (cls == 3) begin
            chk(wr_cnt - w0 == 1, "R5", "write-backs for dirty victim", wr_cnt - w0, 1);
            chk(ops == 2'b10, "R5", "write-back before fetch", ops, 2'b10);
            chk(last_waddr == vline, "R10", "write-back line address", last_waddr, vline);
            for (int i = 0; i < 4; i++)
                chk(mem[int'(vline)*4+i] == gold[int'(vline)*4+i], "R5", "written-back word",
                    mem[int'(vline)*4+i], gold[int'(vline)*4+i]);
        end
        if (!we) chk(rd == gold[a], "R9", "read data", rd, gold[a]);
        if (hw >= 0) begin
            mmru[s] = hw[0];
            if (we) mdir[s][hw] = 1'b1;
        end else begin
            mtag[s][v] = t; mval[s][v] = 1'b1; mdir[s][v] = we; mmru[s] = v;
        end
        if (we) gold[a] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int lat;
        logic [DW-1:0] rd;
        logic [AW-1:0] a_x, b_x, c_x, d_x, wm;
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        for (int i = 0; i < NWORDS; i++) begin
            mem[i] = init_val(i);
            gold[i] = init_val(i);
        end
        for (int s = 0; s < 16; s++) begin
            mmru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                mtag[s][w] = '0; mval[s][w] = 1'b0; mdir[s][w] = 1'b0;
            end
        end
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(cpu_ready == 1'b0, "R1", "cpu_ready after reset", cpu_ready, 0);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);

        // tags 1,2,3,4 in set 3
        a_x = {4'd1, 4'd3, 2'd0};
        b_x = {4'd2, 4'd3, 2'd1};
        c_x = {4'd3, 4'd3, 2'd2};
        d_x = {4'd4, 4'd3, 2'd3};

        // R1: first access after reset misses
        run(1'b0, a_x, 0, lat, rd);
        chk(lat >= 2, "R1", "first access must miss", lat, 2);
        run(1'b0, a_x, 0, lat, rd);
        // R7: write hit, no traffic
        run(1'b1, a_x, 32'hDEAD_0001, lat, rd);
        run(1'b0, b_x, 0, lat, rd);
        // R3: other-way hit then same-cycle repeat
        run(1'b0, a_x, 0, lat, rd);
        chk(lat == 1 && rd == 32'hDEAD_0001, "R3", "other-way hit data", rd, 32'hDEAD_0001);
        run(1'b0, a_x, 0, lat, rd);
        chk(lat == 0, "R3", "repeat after way switch", lat, 0);
        // R4: third tag replaces the way not last used (b_x)
        run(1'b0, c_x, 0, lat, rd);
        run(1'b0, a_x, 0, lat, rd);
        chk(lat == 1, "R4", "retained line after replacement", lat, 1);
        run(1'b0, b_x, 0, lat, rd);
        chk(lat >= 2, "R4", "evicted line misses", lat, 2);
        // R5: dirty a_x is the victim now
        run(1'b0, d_x, 0, lat, rd);
        run(1'b0, a_x, 0, lat, rd);

        // R8: write miss merges into fresh line
        wm = {4'd9, 4'd7, 2'd2};
        run(1'b1, wm, 32'hCAFE_F00D, lat, rd);
        run(1'b0, wm, 0, lat, rd);
        chk(lat == 0 && rd == 32'hCAFE_F00D, "R8", "merged word", rd, 32'hCAFE_F00D);
        run(1'b0, wm ^ 10'd1, 0, lat, rd);
        chk(lat == 0 && rd == init_val(int'(wm ^ 10'd1)), "R8", "neighbour word from memory",
            rd, init_val(int'(wm ^ 10'd1)));

        // random traffic: half uniform, half three-tag conflicts per set
        for (int n = 0; n < 2500; n++) begin
            logic [AW-1:0] ad;
            bit wr;
            wr = ($urandom % 100) < 40;
            if ($urandom % 2) ad = AW'($urandom % NWORDS);
            else ad = {4'($urandom % 3 + 10), 4'($urandom % 16), 2'($urandom % 4)};
            run(wr, ad, $urandom, lat, rd);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule